// File: doc/BRIEF.md
# Multi-Level Daisy-Chain Bus Arbiter

This block decides which of several potential bus masters takes the shared bus next. The masters are split into priority tiers. Every tier has one wired request line, formed by ORing the requests of its members, and one grant line. The grant line is not decoded per master. It enters the first node of the tier's chain and ripples outward. The first node on the way that has a request pending takes the bus and stops the grant from travelling further. A node with no request passes the grant on to its neighbour.

A central unit watches the tier request lines and a shared busy line. While the bus is free it raises the grant of one tier. When several tiers ask at the same time, the tier with the highest index wins. Once a node has claimed the bus it drives busy. The central unit sees busy and withdraws the grant. The owner keeps the bus until its own done strobe arrives. The block has no data stream, so every pin is a plain level-sensitive control or status signal with no valid/ready back-pressure. Master `m` sits at position `m % NODES_PER_LEVEL` in tier `m / NODES_PER_LEVEL`. Position 0 is the node nearest the central unit.

Top module: `dcarb_top`

## Requirements
- R1: After reset, `lvl_grant`, `bus_owner` and `bus_busy` are all zero.
- R2: Within a granted tier, the requesting master at the lowest position becomes owner, and no other master in that chain does.
- R3: A node that holds the grant with no request pending forwards it, so a requester further down the chain still wins when every node before it is idle.
- R4: When several tiers request while the bus is idle, only the grant bit of the highest-numbered requesting tier is raised (`lvl_grant` bit `l` belongs to tier `l`).
- R5: A new grant is raised only at a clock edge where `bus_busy` is low. Requests made while the bus is owned produce no grant.
- R6: Once `bus_busy` is seen high at a clock edge, `lvl_grant` is zero after that edge.
- R7: The owner releases the bus at the first clock edge where its own `mst_done` bit is high. A `mst_done` pulse from a master that does not own the bus leaves the ownership unchanged.
- R8: `bus_owner` is one-hot or zero, and `bus_busy` is high exactly when some master owns the bus.
- R9: With the bus idle, a tier grant appears one clock edge after the request, and ownership appears at the next edge.
- R10: If the granted tier's request line falls before any node claims the grant, the grant is withdrawn at the next edge and nobody becomes owner.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mst_req | input | NUM_LEVELS*NODES_PER_LEVEL | Per-master bus request |
| mst_done | input | NUM_LEVELS*NODES_PER_LEVEL | Per-master end-of-transaction strobe |
| lvl_grant | output | NUM_LEVELS | Grant line entering each tier's chain |
| bus_busy | output | 1 | Bus currently owned |
| bus_owner | output | NUM_LEVELS*NODES_PER_LEVEL | One-hot identity of the current owner |

## Verification
The bench exercises the chain in several ways. Adjacent requesters in one tier show that the nearest node absorbs the grant. A lone requester at the far end shows that the grant is forwarded. Simultaneous requests from both tiers separate the two priorities: tier priority is tested against position priority. Further patterns cover requests raised while the bus is owned, done strobes from non-owners, and a request withdrawn while its grant is in flight. Each of these tells apart grant gating, ownership release and grant retraction.

// File: rtl/dcarb_pkg.sv
package dcarb_pkg;
  typedef enum logic {
    ARB_IDLE  = 1'b0,
    ARB_OFFER = 1'b1
  } arb_state_e;
endpackage

// File: rtl/dcarb_central.sv
module dcarb_central #(
  parameter int NUM_LEVELS = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_LEVELS-1:0] lvl_req,
  input  logic                  bus_busy,
  output logic [NUM_LEVELS-1:0] lvl_grant
);
  import dcarb_pkg::*;

  arb_state_e            state_q;
  logic [NUM_LEVELS-1:0] grant_q;
  logic [NUM_LEVELS-1:0] pick;

  // highest-numbered requesting tier wins
  always_comb begin
    pick = '0;
    for (int l = 0; l < NUM_LEVELS; l++) begin
      if (lvl_req[l]) pick = NUM_LEVELS'(1) << l;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ARB_IDLE;
      grant_q <= '0;
    end else begin
      case (state_q)
        ARB_IDLE: begin
          if (!bus_busy && lvl_req != '0) begin
            grant_q <= pick;
            state_q <= ARB_OFFER;
          end
        end
        ARB_OFFER: begin
          // retract once a node claimed, or the offered tier gave up
          if (bus_busy || (grant_q & lvl_req) == '0) begin
            grant_q <= '0;
            state_q <= ARB_IDLE;
          end
        end
        default: begin
          grant_q <= '0;
          state_q <= ARB_IDLE;
        end
      endcase
    end
  end

  assign lvl_grant = grant_q;
endmodule

// File: rtl/dcarb_chain.sv
module dcarb_chain #(
  parameter int NODES = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             grant_in,
  input  logic             bus_busy,
  input  logic [NODES-1:0] req,
  input  logic [NODES-1:0] done,
  output logic [NODES-1:0] own
);
  logic [NODES-1:0] ripple;

  assign ripple[0] = grant_in;

  genvar p;
  generate
    for (p = 0; p < NODES; p++) begin : g_node
      // a requesting node absorbs the grant, an idle one passes it on
      if (p < NODES - 1) begin : g_pass
        assign ripple[p+1] = ripple[p] & ~req[p];
      end

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          own[p] <= 1'b0;
        end else if (own[p]) begin
          if (done[p]) own[p] <= 1'b0;
        end else if (ripple[p] && req[p] && !bus_busy) begin
          own[p] <= 1'b1;
        end
      end
    end
  endgenerate
endmodule

// File: rtl/dcarb_top.sv
module dcarb_top #(
  parameter int NUM_LEVELS      = 2,
  parameter int NODES_PER_LEVEL = 3
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic [NUM_LEVELS*NODES_PER_LEVEL-1:0] mst_req,
  input  logic [NUM_LEVELS*NODES_PER_LEVEL-1:0] mst_done,
  output logic [NUM_LEVELS-1:0]                 lvl_grant,
  output logic                                  bus_busy,
  output logic [NUM_LEVELS*NODES_PER_LEVEL-1:0] bus_owner
);
  localparam int P = NODES_PER_LEVEL;

  logic [NUM_LEVELS-1:0] lvl_req;

  genvar l;
  generate
    for (l = 0; l < NUM_LEVELS; l++) begin : g_level
      assign lvl_req[l] = |mst_req[l*P +: P];

      dcarb_chain #(.NODES(P)) u_chain (
        .clk      (clk),
        .rst_n    (rst_n),
        .grant_in (lvl_grant[l]),
        .bus_busy (bus_busy),
        .req      (mst_req[l*P +: P]),
        .done     (mst_done[l*P +: P]),
        .own      (bus_owner[l*P +: P])
      );
    end
  endgenerate

  assign bus_busy = |bus_owner;

  dcarb_central #(.NUM_LEVELS(NUM_LEVELS)) u_central (
    .clk       (clk),
    .rst_n     (rst_n),
    .lvl_req   (lvl_req),
    .bus_busy  (bus_busy),
    .lvl_grant (lvl_grant)
  );
endmodule

// File: rtl/dcarb_sva.sv
module dcarb_sva #(
  parameter int NUM_LEVELS      = 2,
  parameter int NODES_PER_LEVEL = 3
) (
  input logic                                  clk,
  input logic                                  rst_n,
  input logic [NUM_LEVELS*NODES_PER_LEVEL-1:0] mst_done,
  input logic [NUM_LEVELS-1:0]                 lvl_grant,
  input logic                                  bus_busy,
  input logic [NUM_LEVELS*NODES_PER_LEVEL-1:0] bus_owner
);
  a_r8_owner_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bus_owner));

  a_r4_grant_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lvl_grant));

  a_r6_grant_drops: assert property (@(posedge clk) disable iff (!rst_n)
    bus_busy |=> lvl_grant == '0);

  a_r5_grant_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_grant != '0 && $past(lvl_grant) == '0) |-> !$past(bus_busy));

  a_r9_owner_after_grant: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_busy && !$past(bus_busy)) |-> $past(lvl_grant) != '0);

  a_r7_release: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_owner & mst_done) != '0 |=> bus_owner == '0);

  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_owner != '0 && (bus_owner & mst_done) == '0) |=> $stable(bus_owner));
endmodule

bind dcarb_top dcarb_sva #(
  .NUM_LEVELS      (NUM_LEVELS),
  .NODES_PER_LEVEL (NODES_PER_LEVEL)
) u_sva (
  .clk       (clk),
  .rst_n     (rst_n),
  .mst_done  (mst_done),
  .lvl_grant (lvl_grant),
  .bus_busy  (bus_busy),
  .bus_owner (bus_owner)
);

// File: tb/dcarb_top_tb.sv
module dcarb_top_tb;
  localparam int L = 2;
  localparam int P = 3;
  localparam int N = L * P;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] mst_req = '0;
  logic [N-1:0] mst_done = '0;
  logic [L-1:0] lvl_grant;
  logic         bus_busy;
  logic [N-1:0] bus_owner;

  int n_vec = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  dcarb_top #(.NUM_LEVELS(L), .NODES_PER_LEVEL(P)) u_dut (
    .clk(clk), .rst_n(rst_n), .mst_req(mst_req), .mst_done(mst_done),
    .lvl_grant(lvl_grant), .bus_busy(bus_busy), .bus_owner(bus_owner)
  );

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic chk_state(input string tag, input logic [L-1:0] g,
                           input logic [N-1:0] own);
    chk({tag, " grant"}, 32'(lvl_grant), 32'(g));
    chk({tag, " owner"}, 32'(bus_owner), 32'(own));
    chk({tag, " busy (R8)"}, 32'(bus_busy), 32'(own != '0));
  endtask

  // owner strobes done and drops its request; bus idle after one edge
  task automatic release_bus(input logic [N-1:0] who);
    mst_done = who;
    mst_req  = mst_req & ~who;
    step();
    mst_done = '0;
    chk("R7 released", 32'(bus_owner), 32'h0);
  endtask

  task automatic t_reset();
    chk_state("R1 reset", '0, '0);
  endtask

  task automatic t_nearest();
    mst_req = 6'b000110;
    step();
    chk_state("R9 grant after one edge", 2'b01, '0);
    step();
    chk_state("R2 nearest requester owns", 2'b01, 6'b000010);
    step();
    chk_state("R6 grant withdrawn", 2'b00, 6'b000010);
    release_bus(6'b000010);
    step();
    chk_state("R3 remaining requester granted", 2'b01, '0);
    step();
    chk_state("R3 far node owns", 2'b00 | lvl_grant, 6'b000100);
    step();
    release_bus(6'b000100);
  endtask

  task automatic t_forward();
    mst_req = 6'b100000;
    step(2);
    chk_state("R3 forwarded to last node", 2'b10, 6'b100000);
    step();
    release_bus(6'b100000);
  endtask

  task automatic t_levels();
    mst_req = 6'b010001;
    step();
    chk_state("R4 upper tier granted", 2'b10, '0);
    step();
    chk_state("R4 upper tier owns", 2'b10, 6'b010000);
    step();
    release_bus(6'b010000);
    step();
    chk_state("R4 lower tier after release", 2'b01, '0);
    step();
    chk_state("R4 lower tier owns", 2'b01, 6'b000001);
    step();
    release_bus(6'b000001);
  endtask

  task automatic t_busy_block();
    mst_req = 6'b000100;
    step(3);
    chk_state("R5 setup owner", 2'b00, 6'b000100);
    mst_req = 6'b100101;
    step(3);
    chk_state("R5 no grant while busy", 2'b00, 6'b000100);
    mst_done = 6'b100001;
    step();
    mst_done = '0;
    chk_state("R7 foreign done ignored", 2'b00, 6'b000100);
    release_bus(6'b000100);
    step();
    chk_state("R5 pending served after release", 2'b10, '0);
    step();
    chk_state("R5 pending owner", 2'b10, 6'b100000);
    step();
    release_bus(6'b100000);
    step();
    chk_state("R5 last pending granted", 2'b01, '0);
    step();
    step();
    release_bus(6'b000001);
  endtask

  task automatic t_withdraw();
    mst_req = 6'b001000;
    step();
    chk_state("R10 grant offered", 2'b10, '0);
    mst_req = '0;
    step();
    chk_state("R10 grant retracted", 2'b00, '0);
    step(2);
    chk_state("R10 stays idle", 2'b00, '0);
  endtask

  initial begin
    #(8 * 20000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    step(3);
    t_reset();
    rst_n = 1'b1;
    step();
    t_reset();
    t_nearest();
    t_forward();
    t_levels();
    t_busy_block();
    t_withdraw();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule